// File: doc/BRIEF.md
# Magnetic Sensor Result Formatter and Register Bank

This block takes the 10-bit sample stream of a position-sensing ADC and turns it into the readable result of the sensor. In fast mode every accepted sample becomes the new result. In slow mode four consecutive samples are summed and the sum is shifted right by two, so the result updates once per four samples. An optional polarity reversal replaces the code with its complement, 1023 minus the value. An even-parity bit and a compensation-finished flag are packed next to the upper two result bits.

The same block holds the control settings written over the serial register port: power-down, polarity, averaging mode, a 10-bit offset value and a 2-bit sensitivity code. These values drive the analog front end directly. A read port with a one-cycle registered return serves the serial slave. Reading the low result byte also captures the matching upper byte, so a two-byte read always returns a consistent pair.

Top module: `sensor_fmt_regs`

## Requirements
- R1: After reset, every register reads 0x00 and the outputs pwrDown, polarityRev, slowMode, offsetVal and sensCode are all 0.
- R2: Address 0x00 returns result bits 7..0. Address 0x01 returns result bits 9..8 in bits 1..0.
- R3: Address 0x01 bit 2 is the even-parity bit of the 10-bit result: the eleven bits together hold an even number of ones.
- R4: Address 0x01 bit 3 equals compDone while power-down is clear, and reads 0 while power-down is set. Bits 7..4 read 0.
- R5: Address 0x02 is a read/write control byte: bit 0 power-down, bit 1 polarity reversal, bit 2 slow mode, bits 7..3 read 0. The bits drive pwrDown, polarityRev and slowMode.
- R6: In fast mode, a sample with sampleValid high at a clock edge is the result from that edge on.
- R7: In slow mode, the result changes only on the fourth accepted sample, to the four-sample sum shifted right by two.
- R8: With polarity reversal set, the stored result is 1023 minus the fast-mode sample or the slow-mode average, and parity is taken over that stored value.
- R9: While power-down is set, samples are ignored, the result is held and a partial slow-mode sum is discarded.
- R10: Address 0x03 holds offset bits 9..2 and address 0x04 bits 1..0 hold offset bits 1..0. Address 0x0B bits 1..0 hold the sensitivity code. All are read/write and drive offsetVal and sensCode.
- R11: addrHit is high for addresses 0x00 to 0x07 and 0x0B only. Unlisted addresses read 0x00. Writes to 0x00, 0x01 and 0x05 to 0x07 and to unlisted addresses change nothing.
- R12: When a read of 0x01 comes right after a read of 0x00, with no other read between them, it returns the upper byte as it stood at the 0x00 read. Otherwise a read of 0x01 returns the live value.
- R13: regRdData takes the addressed value on the clock edge where regRdEn is high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | A new ADC sample is on sampleData |
| sampleData | input | 10 | Raw ADC code |
| compDone | input | 1 | Offset compensation has finished |
| regAddr | input | 8 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 8 | Registered read data |
| addrHit | output | 1 | regAddr names a valid register |
| pwrDown | output | 1 | Power-down control to the front end |
| polarityRev | output | 1 | Polarity reversal control |
| slowMode | output | 1 | Averaging mode control |
| offsetVal | output | 10 | Offset value to the front end |
| sensCode | output | 2 | Sensitivity selection |

## Verification
A fast-mode sample is in the result after the edge where sampleValid is high. A slow-mode result is due after the edge of the fourth sample. A control write takes effect at its own edge. Read data comes one edge after the read strobe. The bench drives all inputs on the falling edge. A reference model updates its expected state when it drives a stimulus. Each read pushes its expected byte into a queue, and the monitor compares that byte against regRdData at the falling edge after the read edge. addrHit and the control outputs are combinational or already registered, so the bench checks them at the falling edge after they settle.

// File: rtl/sensor_fmt_pkg.sv
package sensor_fmt_pkg;
  localparam int SAMPLE_W = 10;
  localparam int AVG_LOG2 = 2;
  localparam int BYTE_W   = 8;

  localparam logic [7:0] ADDR_RES_LO = 8'h00;
  localparam logic [7:0] ADDR_RES_HI = 8'h01;
  localparam logic [7:0] ADDR_CTRL   = 8'h02;
  localparam logic [7:0] ADDR_OFFS_H = 8'h03;
  localparam logic [7:0] ADDR_OFFS_L = 8'h04;
  localparam logic [7:0] ADDR_RSV_LO = 8'h05;
  localparam logic [7:0] ADDR_RSV_HI = 8'h07;
  localparam logic [7:0] ADDR_SENS   = 8'h0B;

  typedef struct packed {
    logic hold;
    logic invert;
    logic slow;
  } fmt_strobe_t;
endpackage

// File: rtl/sensor_fmt_datapath.sv
module sensor_fmt_datapath
  import sensor_fmt_pkg::*;
#(
  parameter int W = SAMPLE_W,
  parameter int AVG_BITS = AVG_LOG2
) (
  input  logic        clk,
  input  logic        rstN,
  input  fmt_strobe_t stb,
  input  logic        sampleValid,
  input  logic [W-1:0] sampleData,
  output logic [W-1:0] resultQ,
  output logic        parityQ
);
  localparam int ACC_W = W + AVG_BITS;
  localparam logic [AVG_BITS-1:0] CNT_LAST = '1;

  logic [ACC_W-1:0]    accQ;
  logic [AVG_BITS-1:0] cntQ;
  logic [ACC_W-1:0]    sumNext;
  logic [W-1:0]        picked;
  logic [W-1:0]        shaped;

  always_comb begin
    sumNext = accQ + ACC_W'(sampleData);
    picked  = stb.slow ? sumNext[ACC_W-1:AVG_BITS] : sampleData;
    shaped  = stb.invert ? ~picked : picked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      parityQ <= 1'b0;
      accQ    <= '0;
      cntQ    <= '0;
    end else if (stb.hold) begin
      accQ <= '0;
      cntQ <= '0;
    end else if (sampleValid) begin
      if (!stb.slow || cntQ == CNT_LAST) begin
        resultQ <= shaped;
        parityQ <= ^shaped;
        accQ    <= '0;
        cntQ    <= '0;
      end else begin
        accQ <= sumNext;
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  // R6: in fast mode with no inversion, the next result is the sample just taken
  p_fast_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !stb.hold && !stb.slow && !stb.invert) |=> (resultQ == $past(sampleData)));
  // R9: power-down freezes the result
  p_pd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.hold |=> $stable(resultQ));
  // R3: the stored parity always matches the stored result
  p_parity_even_r3: assert property (@(posedge clk) disable iff (!rstN)
    (^{resultQ, parityQ}) == 1'b0);
  // R7: in slow mode the result only moves on the last sample of a group
  p_slow_group_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !stb.hold && stb.slow && cntQ != CNT_LAST) |=> $stable(resultQ));
endmodule

// File: rtl/sensor_fmt_ctrl.sv
module sensor_fmt_ctrl
  import sensor_fmt_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  logic        regRdEn,
  input  logic        compDone,
  input  logic [W-1:0] resultQ,
  input  logic        parityQ,
  output logic [7:0]  regRdData,
  output logic        addrHit,
  output fmt_strobe_t stb,
  output logic [2:0]  ctrlQ,
  output logic [W-1:0] offsQ,
  output logic [1:0]  sensQ
);
  localparam int HI_BITS = W - BYTE_W;

  logic [7:0] shadowQ;
  logic       armedQ;
  logic [7:0] upperLive;
  logic [7:0] rdMux;
  logic       statusFlag;

  assign stb.hold   = ctrlQ[0];
  assign stb.invert = ctrlQ[1];
  assign stb.slow   = ctrlQ[2];

  always_comb begin
    statusFlag = compDone & ~ctrlQ[0];
    upperLive  = {4'b0, statusFlag, parityQ, resultQ[W-1 -: HI_BITS]};
    addrHit    = (regAddr <= ADDR_RSV_HI) || (regAddr == ADDR_SENS);
    case (regAddr)
      ADDR_RES_LO: rdMux = resultQ[BYTE_W-1:0];
      ADDR_RES_HI: rdMux = armedQ ? shadowQ : upperLive;
      ADDR_CTRL:   rdMux = {5'b0, ctrlQ};
      ADDR_OFFS_H: rdMux = offsQ[W-1:2];
      ADDR_OFFS_L: rdMux = {6'b0, offsQ[1:0]};
      ADDR_SENS:   rdMux = {6'b0, sensQ};
      default:     rdMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      offsQ     <= '0;
      sensQ     <= '0;
      shadowQ   <= '0;
      armedQ    <= 1'b0;
      regRdData <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          ADDR_CTRL:   ctrlQ <= regWrData[2:0];
          ADDR_OFFS_H: offsQ[W-1:2] <= regWrData;
          ADDR_OFFS_L: offsQ[1:0] <= regWrData[1:0];
          ADDR_SENS:   sensQ <= regWrData[1:0];
          default: ;
        endcase
      end
      if (regRdEn) begin
        regRdData <= rdMux;
        armedQ    <= (regAddr == ADDR_RES_LO);
        if (regAddr == ADDR_RES_LO) shadowQ <= upperLive;
      end
    end
  end

  // R5: a control write lands in the control bits at its edge
  p_ctrl_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CTRL) |=> (ctrlQ == $past(regWrData[2:0])));
  // R12: the captured upper byte only moves on a low-byte read
  p_shadow_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdEn && regAddr == ADDR_RES_LO) |=> $stable(shadowQ));
  // R13: read data holds between reads
  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));
endmodule

// File: rtl/sensor_fmt_regs.sv
module sensor_fmt_regs
  import sensor_fmt_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic [W-1:0] sampleData,
  input  logic         compDone,
  input  logic [7:0]   regAddr,
  input  logic         regWrEn,
  input  logic [7:0]   regWrData,
  input  logic         regRdEn,
  output logic [7:0]   regRdData,
  output logic         addrHit,
  output logic         pwrDown,
  output logic         polarityRev,
  output logic         slowMode,
  output logic [W-1:0] offsetVal,
  output logic [1:0]   sensCode
);
  fmt_strobe_t  stb;
  logic [W-1:0] resultQ;
  logic         parityQ;
  logic [2:0]   ctrlQ;

  sensor_fmt_ctrl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .compDone(compDone),
    .resultQ(resultQ), .parityQ(parityQ), .regRdData(regRdData),
    .addrHit(addrHit), .stb(stb), .ctrlQ(ctrlQ), .offsQ(offsetVal),
    .sensQ(sensCode)
  );

  sensor_fmt_datapath #(.W(W), .AVG_BITS(AVG_LOG2)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleValid(sampleValid),
    .sampleData(sampleData), .resultQ(resultQ), .parityQ(parityQ)
  );

  assign pwrDown     = ctrlQ[0];
  assign polarityRev = ctrlQ[1];
  assign slowMode    = ctrlQ[2];
endmodule

// File: tb/tb_sensor_fmt_regs.sv
module tb_sensor_fmt_regs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [9:0] sampleData = '0;
  logic       compDone = 1'b0;
  logic [7:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       addrHit, pwrDown, polarityRev, slowMode;
  logic [9:0] offsetVal;
  logic [1:0] sensCode;

  sensor_fmt_regs dut (.*);

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model state
  int mRes = 0;
  int mAcc = 0;
  int mCnt = 0;
  bit mPd = 0, mPol = 0, mSlow = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdIssued = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdIssued <= regRdEn;

  // monitor: compares the registered read data one edge after the strobe
  always @(negedge clk) begin
    if (rdIssued && expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(regRdData === e, t, regRdData, e);
    end
  end

  function automatic logic [7:0] upperExp(input int res, input bit flag);
    logic [9:0] r;
    int ones;
    r = 10'(res);
    ones = $countones(r);
    return {4'b0, flag, (ones % 2 == 1), r[9:8]};
  endfunction

  task automatic rdExp(input logic [7:0] a, input logic [7:0] e, input string tag);
    regAddr = a;
    regRdEn = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regAddr = a;
    regWrData = d;
    regWrEn = 1'b1;
    if (a == 8'h02) begin
      mPd = d[0]; mPol = d[1]; mSlow = d[2];
      if (mPd) begin mAcc = 0; mCnt = 0; end
    end
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sendSample(input int x);
    sampleData = 10'(x);
    sampleValid = 1'b1;
    if (!mPd) begin
      if (!mSlow) begin
        mRes = mPol ? 1023 - x : x;
        mAcc = 0; mCnt = 0;
      end else begin
        mAcc += x; mCnt++;
        if (mCnt == 4) begin
          mRes = mPol ? 1023 - (mAcc / 4) : (mAcc / 4);
          mAcc = 0; mCnt = 0;
        end
      end
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic readResult(input string tag);
    rdExp(8'h00, 8'(mRes & 255), tag);
    rdExp(8'h01, upperExp(mRes, compDone && !mPd), tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({pwrDown, polarityRev, slowMode, offsetVal, sensCode} === '0, "R1 outputs", 0, 0);
    rdExp(8'h00, 8'h00, "R1 res lo");
    rdExp(8'h01, 8'h00, "R1 res hi");
    rdExp(8'h02, 8'h00, "R1 ctrl");
    rdExp(8'h03, 8'h00, "R1 offs");
    rdExp(8'h0B, 8'h00, "R1 sens");

    // R6 R2 R3 R4 fast mode
    compDone = 1'b1;
    sendSample(10'h2A5);
    readResult("R6 R2 R3 fast 2A5");
    sendSample(10'h0FF);
    readResult("R6 R3 R4 fast 0FF");
    sendSample(10'h300);
    readResult("R2 R3 fast 300");
    compDone = 1'b0;
    readResult("R4 compDone low");
    compDone = 1'b1;

    // R8 polarity in fast mode
    wr(8'h02, 8'h02);
    check(polarityRev === 1'b1, "R5 polarityRev", polarityRev, 1);
    rdExp(8'h02, 8'h02, "R5 ctrl readback");
    sendSample(100);
    readResult("R8 fast invert");
    wr(8'h02, 8'h00);

    // R7 slow mode averaging
    wr(8'h02, 8'hFC);
    check(slowMode === 1'b1 && pwrDown === 1'b0, "R5 slowMode", slowMode, 1);
    rdExp(8'h02, 8'h04, "R5 ctrl upper bits zero");
    sendSample(100);
    sendSample(200);
    sendSample(300);
    readResult("R7 held before fourth");
    sendSample(404);
    readResult("R7 average 251");
    // R8 with slow mode
    wr(8'h02, 8'h06);
    sendSample(1000); sendSample(1000); sendSample(1000); sendSample(1003);
    readResult("R8 slow invert");
    wr(8'h02, 8'h04);

    // R9 power-down discards partial sum
    sendSample(800); sendSample(800);
    wr(8'h02, 8'h05);
    check(pwrDown === 1'b1, "R9 pwrDown out", pwrDown, 1);
    sendSample(5); sendSample(6); sendSample(7); sendSample(8);
    readResult("R9 R4 held in power-down");
    wr(8'h02, 8'h04);
    sendSample(40); sendSample(80); sendSample(120);
    readResult("R9 partial after wake");
    sendSample(164);
    readResult("R9 fresh group 101");
    wr(8'h02, 8'h00);

    // R10 offset and sensitivity
    wr(8'h03, 8'hA7);
    wr(8'h04, 8'hFE);
    wr(8'h0B, 8'hFF);
    check(offsetVal === 10'h29E, "R10 offsetVal", offsetVal, 10'h29E);
    check(sensCode === 2'd3, "R10 sensCode", sensCode, 3);
    rdExp(8'h03, 8'hA7, "R10 offs high");
    rdExp(8'h04, 8'h02, "R10 offs low");
    rdExp(8'h0B, 8'h03, "R10 sens");

    // R11 decode and ignored writes
    regAddr = 8'h07; #1;
    check(addrHit === 1'b1, "R11 hit 07", addrHit, 1);
    regAddr = 8'h08; #1;
    check(addrHit === 1'b0, "R11 miss 08", addrHit, 0);
    regAddr = 8'h0B; #1;
    check(addrHit === 1'b1, "R11 hit 0B", addrHit, 1);
    regAddr = 8'h0C; #1;
    check(addrHit === 1'b0, "R11 miss 0C", addrHit, 0);
    @(negedge clk);
    wr(8'h00, 8'h55);
    wr(8'h06, 8'h55);
    wr(8'h10, 8'h55);
    readResult("R11 result untouched");
    rdExp(8'h06, 8'h00, "R11 reserved reads 0");
    rdExp(8'h10, 8'h00, "R11 unlisted reads 0");
    check(offsetVal === 10'h29E && sensCode === 2'd3 && pwrDown === 1'b0, "R11 controls untouched", offsetVal, 10'h29E);

    // R12 coherent pair
    sendSample(10'h1C3);
    rdExp(8'h00, 8'hC3, "R12 low");
    begin
      int old;
      old = mRes;
      sendSample(10'h244);
      rdExp(8'h01, upperExp(old, 1'b1), "R12 shadow upper");
    end
    rdExp(8'h01, upperExp(mRes, 1'b1), "R12 live upper");
    rdExp(8'h00, 8'h44, "R12 low again");
    rdExp(8'h02, 8'h00, "R12 other read disarms");
    rdExp(8'h01, upperExp(mRes, 1'b1), "R12 live after disarm");

    // R13 read data holds without a strobe
    repeat (2) @(negedge clk);
    check(regRdData === upperExp(mRes, 1'b1), "R13 hold", regRdData, upperExp(mRes, 1'b1));

    repeat (3) @(negedge clk);
    finish();
  end
endmodule